// File: doc/BRIEF.md
# Programmable Interval Timer

This block holds three 16-bit down-counting timer channels behind one byte-wide register port. Software selects a channel and its operating mode with a control byte, then loads the 16-bit start value as two bytes, low byte first. It reads the value back the same way. A latch command freezes a snapshot of one channel's count, so that a two-byte read is coherent while the counter keeps running.

All channels count on a single-cycle tick enable that the surrounding logic derives from a 1.193180 MHz reference, so the block runs entirely in the bus clock domain. Each channel drives an output bit. Three behaviours are supported for that bit: a one-shot that goes high at terminal count, a rate generator that pulses low for one tick, and a square wave. A status byte shows the third channel's output in bit 5. Control bytes that ask for an unsupported feature are rejected with a one-cycle error pulse.

Each channel is a four-state machine:
- CH_IDLE: halted, with no valid start value.
- CH_LOW_HELD: the low byte has been written and the high byte is awaited.
- CH_COUNTING: the channel is running.
- CH_EXPIRED: the one-shot has reached terminal count.

The transitions are:
- A data write in CH_IDLE, CH_COUNTING or CH_EXPIRED goes to CH_LOW_HELD.
- A data write in CH_LOW_HELD goes to CH_COUNTING if the assembled value is non-zero, and to CH_IDLE if it is zero.
- A tick in CH_COUNTING under the one-shot mode, with the count at 1, goes to CH_EXPIRED.

Top module: `interval_timer`

## Requirements
- R1: After reset every channel's count reads 0x00 then 0x00, every output bit is low, no snapshot is held, `cfg_err` is low and `port_status` is 0x00.
- R2: A control byte at address 3 is decoded as follows: bits 7:6 select the channel, bits 5:4 give the access kind, bits 3:1 give the mode and bit 0 selects BCD. A select value of 3 requests read-back, which is not supported; `cfg_err` is high in the cycle after that write, and no channel changes.
- R3: A non-latch control byte is rejected, with `cfg_err` high in the next cycle and the channel's mode unchanged, when any of these holds: the access kind is not 3 (low byte then high byte); the mode is not 0, 2 or 3; or the BCD bit is 1. An accepted control byte leaves `cfg_err` low.
- R4: A data write at address 0 to 2 while the channel awaits its low byte replaces count bits 7:0, halts the channel and drives its output low from the next cycle.
- R5: The following data write supplies bits 15:8 and copies the 16-bit value into the period. A non-zero period starts counting. A zero period leaves the channel halted with its output low and its count at zero.
- R6: Reads of a channel's data address return the low byte and the high byte of the live count in alternation.
- R7: Access kind 0 latches the selected count and resets that channel's read order to the low byte, but only if no snapshot is already held. A second latch while one is held has no effect. The held value is returned until its high byte has been read, and then reads return the live count again.
- R8: Mode 0: each tick decrements the count. On the tick that takes it from 1 to 0 the output goes high, and it then stays high with the count frozen at 0.
- R9: Mode 2: the output goes high when counting starts. On the tick that finds the count at 1, the count reloads from the period and the output is low for exactly that one tick.
- R10: Mode 3: counting starts at half the period with the output high. Every time the count reaches 1, a tick reloads half the period and toggles the output.
- R11: `port_status` bit 5 equals channel 2's output bit, and its other bits are 0.
- R12: When a data write and a tick fall in the same cycle, the write wins and the count is not decremented. A latch in the same cycle as a tick captures the value from before that tick.
- R13: With no tick and no data write, a channel's count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Single-cycle count enable at the timer rate |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (advances read order) |
| bus_addr | input | 2 | 0 to 2 select a channel's data byte, 3 is the control byte |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while bus_rd is high |
| chan_out | output | 3 | Output bit of each channel |
| port_status | output | 8 | Status byte with channel 2's output in bit 5 |
| cfg_err | output | 1 | One-cycle pulse after a rejected control byte |

## Verification
The two functions that can land in the same clock edge are the bus access and the counting tick. The bench provokes this twice: with a low-byte write that carries a tick, and with a latch command that carries a tick. In the first case it expects the written byte unchanged and the output forced low. In the second it expects the snapshot to hold the pre-tick value while the live count reads one lower. The scoreboard judges both through ordinary byte reads and the status port.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int NUM_CH  = 3;
    localparam int ADDR_W  = 2;
    localparam int STATUS_BIT = 5;
    localparam int STATUS_CH  = 2;

    localparam logic [1:0] SEL_READBACK = 2'd3;
    localparam logic [1:0] ACC_LATCH    = 2'd0;
    localparam logic [1:0] ACC_LOHI     = 2'd3;

    localparam logic [2:0] MODE_TERM   = 3'd0;
    localparam logic [2:0] MODE_RATE   = 3'd2;
    localparam logic [2:0] MODE_SQUARE = 3'd3;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_LOW_HELD,
        CH_COUNTING,
        CH_EXPIRED
    } ch_state_t;
endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int CH_CNT = NUM_CH
) (
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_byte,
    output logic [CH_CNT-1:0] latch_hit,
    output logic [CH_CNT-1:0] cfg_hit,
    output logic [2:0]        cfg_mode,
    output logic              ctrl_bad
);
    logic [1:0] sel_f;
    logic [1:0] acc_f;
    logic       bcd_f;
    logic       readback;
    logic       mode_ok;
    logic       cfg_bad;

    assign sel_f    = ctrl_byte[7:6];
    assign acc_f    = ctrl_byte[5:4];
    assign cfg_mode = ctrl_byte[3:1];
    assign bcd_f    = ctrl_byte[0];

    assign readback = (sel_f == SEL_READBACK);
    assign mode_ok  = (cfg_mode == MODE_TERM) || (cfg_mode == MODE_RATE) ||
                      (cfg_mode == MODE_SQUARE);
    assign cfg_bad  = (acc_f != ACC_LATCH) &&
                      ((acc_f != ACC_LOHI) || !mode_ok || bcd_f);
    assign ctrl_bad = ctrl_wr && (readback || cfg_bad);

    for (genvar i = 0; i < CH_CNT; i++) begin : g_sel
        assign latch_hit[i] = ctrl_wr && !readback && (acc_f == ACC_LATCH) &&
                              (sel_f == 2'(i));
        assign cfg_hit[i]   = ctrl_wr && !readback && !cfg_bad &&
                              (acc_f != ACC_LATCH) && (sel_f == 2'(i));
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_data,
    input  logic              rd_data,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              latch_cmd,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_mode,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              ch_out
);
    ch_state_t          state, state_nx;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   period;
    logic [CNT_W-1:0]   latch_val;
    logic [CNT_W-1:0]   arm_period;
    logic [2:0]         mode;
    logic               latch_on;
    logic               rd_hi;
    logic               wr_low;
    logic               wr_high;
    logic               run_tick;
    logic               at_one;

    function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] p);
        return ((p >> 1) == '0) ? CNT_W'(1) : (p >> 1);
    endfunction

    assign wr_low     = wr_data && (state != CH_LOW_HELD);
    assign wr_high    = wr_data && (state == CH_LOW_HELD);
    assign arm_period = {wdata, count[BYTE_W-1:0]};
    assign run_tick   = tick && !wr_data && (state == CH_COUNTING);
    assign at_one     = (count == CNT_W'(1));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE, CH_EXPIRED: begin
                if (wr_data) state_nx = CH_LOW_HELD;
            end
            CH_LOW_HELD: begin
                if (wr_data) state_nx = (arm_period != '0) ? CH_COUNTING : CH_IDLE;
            end
            CH_COUNTING: begin
                if (wr_data)
                    state_nx = CH_LOW_HELD;
                else if (tick && mode == MODE_TERM && at_one)
                    state_nx = CH_EXPIRED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    // count, period and mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            period <= '0;
            mode   <= MODE_TERM;
        end else begin
            if (cfg_wr) mode <= cfg_mode;
            if (wr_low) begin
                count[BYTE_W-1:0] <= wdata;
            end else if (wr_high) begin
                period <= arm_period;
                count  <= (mode == MODE_SQUARE && arm_period != '0) ?
                          half_of(arm_period) : arm_period;
            end else if (run_tick) begin
                if (mode == MODE_RATE && at_one)
                    count <= period;
                else if (mode == MODE_SQUARE && at_one)
                    count <= half_of(period);
                else
                    count <= count - CNT_W'(1);
            end
        end
    end

    // snapshot and read order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_val <= '0;
            latch_on  <= 1'b0;
            rd_hi     <= 1'b0;
        end else if (latch_cmd) begin
            if (!latch_on) begin
                latch_on  <= 1'b1;
                latch_val <= count;
                rd_hi     <= 1'b0;
            end
        end else if (rd_data) begin
            rd_hi <= !rd_hi;
            if (latch_on && rd_hi) latch_on <= 1'b0;
        end
    end

    // output bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_out <= 1'b0;
        end else if (wr_low) begin
            ch_out <= 1'b0;
        end else if (wr_high) begin
            ch_out <= (arm_period != '0) && (mode != MODE_TERM);
        end else if (run_tick) begin
            if (mode == MODE_TERM) begin
                if (at_one) ch_out <= 1'b1;
            end else if (mode == MODE_RATE) begin
                ch_out <= !at_one;
            end else if (mode == MODE_SQUARE) begin
                if (at_one) ch_out <= !ch_out;
            end
        end
    end

    always_comb begin
        if (latch_on) rd_byte = rd_hi ? latch_val[CNT_W-1:BYTE_W] : latch_val[BYTE_W-1:0];
        else          rd_byte = rd_hi ? count[CNT_W-1:BYTE_W]     : count[BYTE_W-1:0];
    end

    assert_lowbyte_forces_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_low |=> !ch_out);
    assert_zero_period_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_high && arm_period == '0) |=> (state == CH_IDLE && !ch_out));
    assert_hold_without_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_data) |=> $stable(count));
    assert_term_raises_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && mode == MODE_TERM && at_one) |=> (ch_out && state == CH_EXPIRED));
    assert_snapshot_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_on |=> $stable(latch_val));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] chan_out,
    output logic [BYTE_W-1:0] port_status,
    output logic              cfg_err
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

    logic [NUM_CH-1:0] latch_hit;
    logic [NUM_CH-1:0] cfg_hit;
    logic [2:0]        cfg_mode;
    logic              ctrl_bad;
    logic [BYTE_W-1:0] ch_byte [NUM_CH];

    pit_ctrl_decode #(.CH_CNT(NUM_CH)) u_decode (
        .ctrl_wr   (bus_wr && bus_addr == CTRL_ADDR),
        .ctrl_byte (bus_wdata),
        .latch_hit (latch_hit),
        .cfg_hit   (cfg_hit),
        .cfg_mode  (cfg_mode),
        .ctrl_bad  (ctrl_bad)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pit_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_en),
            .wr_data   (bus_wr && bus_addr == ADDR_W'(i)),
            .rd_data   (bus_rd && bus_addr == ADDR_W'(i)),
            .wdata     (bus_wdata),
            .latch_cmd (latch_hit[i]),
            .cfg_wr    (cfg_hit[i]),
            .cfg_mode  (cfg_mode),
            .rd_byte   (ch_byte[i]),
            .ch_out    (chan_out[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (bus_rd && bus_addr == ADDR_W'(i)) bus_rdata = ch_byte[i];
    end

    always_comb begin
        port_status = '0;
        port_status[STATUS_BIT] = chan_out[STATUS_CH];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= ctrl_bad;
    end

    assert_readback_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_ADDR && bus_wdata[7:6] == SEL_READBACK) |=> cfg_err);
    assert_good_ctrl_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_ADDR && bus_wdata == 8'h30) |=> !cfg_err);
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
    localparam int K_RD = 0, K_OUT = 1, K_STAT = 2, K_ERR = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [2:0] chan_out;
    logic [7:0] port_status;
    logic       cfg_err;

    typedef struct {
        int         kind;
        int         idx;
        logic [7:0] exp;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    interval_timer u_interval_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .chan_out(chan_out), .port_status(port_status),
        .cfg_err(cfg_err)
    );

    // monitor: pops expectations mid-cycle and compares
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_OUT:   act = {7'd0, chan_out[it.idx]};
                K_STAT:  act = port_status;
                default: act = {7'd0, cfg_err};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d idx=%0d actual=%02h expected=%02h",
                         it.req, it.kind, it.idx, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; tick_en = 1'b0;
    endtask

    task automatic put(int kind, int idx, logic [7:0] exp, string req);
        exp_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, logic t);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = t;
        step();
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
        bus_rd = 1'b1; bus_addr = a;
        put(K_RD, 0, exp, req);
        step();
    endtask

    task automatic chk(int kind, int idx, logic [7:0] exp, string req);
        put(kind, idx, exp, req);
        step();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            step();
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(K_OUT, 0, 8'h00, "R1");
        chk(K_STAT, 0, 8'h00, "R1");
        chk(K_ERR, 0, 8'h00, "R1");
        rd(2'd0, 8'h00, "R1");
        rd(2'd0, 8'h00, "R1");

        // R8 one-shot on channel 0, R6 live reads
        wr(2'd3, 8'h30, 1'b0);
        chk(K_ERR, 0, 8'h00, "R3");
        wr(2'd0, 8'h05, 1'b0);
        wr(2'd0, 8'h00, 1'b0);
        chk(K_OUT, 0, 8'h00, "R8");
        rd(2'd0, 8'h05, "R6");
        rd(2'd0, 8'h00, "R6");
        ticks(4);
        rd(2'd0, 8'h01, "R8");
        rd(2'd0, 8'h00, "R13");
        chk(K_OUT, 0, 8'h00, "R8");
        ticks(1);
        chk(K_OUT, 0, 8'h01, "R8");
        ticks(2);
        rd(2'd0, 8'h00, "R8");
        chk(K_OUT, 0, 8'h01, "R8");

        // R7 snapshot on channel 1 (mode 2)
        wr(2'd3, 8'h74, 1'b0);
        wr(2'd1, 8'h34, 1'b0);
        wr(2'd1, 8'h12, 1'b0);
        chk(K_OUT, 1, 8'h01, "R9");
        wr(2'd3, 8'h40, 1'b0);
        ticks(3);
        wr(2'd3, 8'h40, 1'b0);
        rd(2'd1, 8'h34, "R7");
        rd(2'd1, 8'h12, "R7");
        rd(2'd1, 8'h31, "R7");
        rd(2'd1, 8'h12, "R6");
        // R12 latch in the same cycle as a tick
        wr(2'd3, 8'h40, 1'b1);
        rd(2'd1, 8'h31, "R12");
        rd(2'd1, 8'h12, "R12");
        rd(2'd1, 8'h30, "R12");

        // R9 rate generator on channel 0, R4 low byte halts
        wr(2'd3, 8'h34, 1'b0);
        wr(2'd0, 8'h03, 1'b0);
        chk(K_OUT, 0, 8'h00, "R4");
        wr(2'd0, 8'h00, 1'b0);
        chk(K_OUT, 0, 8'h01, "R9");
        ticks(2);
        chk(K_OUT, 0, 8'h01, "R9");
        ticks(1);
        chk(K_OUT, 0, 8'h00, "R9");
        ticks(1);
        chk(K_OUT, 0, 8'h01, "R9");

        // R10 square wave on channel 2, R11 status port
        wr(2'd3, 8'hB6, 1'b0);
        wr(2'd2, 8'h06, 1'b0);
        wr(2'd2, 8'h00, 1'b0);
        chk(K_STAT, 0, 8'h20, "R11");
        ticks(2);
        chk(K_OUT, 2, 8'h01, "R10");
        ticks(1);
        chk(K_OUT, 2, 8'h00, "R10");
        chk(K_STAT, 0, 8'h00, "R11");
        ticks(3);
        chk(K_OUT, 2, 8'h01, "R10");

        // R2 / R3 rejected control bytes
        wr(2'd3, 8'hC0, 1'b0);
        chk(K_ERR, 0, 8'h01, "R2");
        chk(K_ERR, 0, 8'h00, "R2");
        wr(2'd3, 8'h10, 1'b0);
        chk(K_ERR, 0, 8'h01, "R3");
        wr(2'd3, 8'h32, 1'b0);
        chk(K_ERR, 0, 8'h01, "R3");
        wr(2'd3, 8'h31, 1'b0);
        chk(K_ERR, 0, 8'h01, "R3");
        wr(2'd0, 8'h02, 1'b0);
        chk(K_OUT, 0, 8'h00, "R4");
        wr(2'd0, 8'h00, 1'b0);
        chk(K_OUT, 0, 8'h01, "R3");

        // R12 write wins over a same-cycle tick on channel 2
        wr(2'd2, 8'h09, 1'b1);
        chk(K_STAT, 0, 8'h00, "R12");
        rd(2'd2, 8'h09, "R12");
        rd(2'd2, 8'h00, "R12");
        wr(2'd2, 8'h00, 1'b0);
        rd(2'd2, 8'h04, "R10");
        rd(2'd2, 8'h00, "R10");
        chk(K_STAT, 0, 8'h20, "R11");

        // R5 zero period keeps channel 0 halted
        wr(2'd0, 8'h00, 1'b0);
        wr(2'd0, 8'h00, 1'b0);
        chk(K_OUT, 0, 8'h00, "R5");
        ticks(2);
        rd(2'd0, 8'h00, "R5");
        rd(2'd0, 8'h00, "R5");
        chk(K_OUT, 0, 8'h00, "R5");

        step();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule